// File: doc/BRIEF.md
# Packed double-to-int32 truncating converter

This block takes a 128-bit word that holds two IEEE-754 double-precision numbers and turns each one into a signed 32-bit integer. Rounding is always toward zero. The two integers are packed into a 64-bit result. Each conversion is classified on its own. The outcomes are: zero, a magnitude below one, an ordinary in-range value, the single negative boundary value, out of range, or special (NaN or infinity). The per-lane invalid and inexact conditions are then combined into two flags.

An operation starts when the input strobe is high at a rising clock edge. The result, flags and exception request are registered at that same edge and hold until the next strobe. A lane that cannot be represented is invalid. When the invalid mask input is high, an invalid lane writes the integer indefinite pattern 0x80000000. When the mask is low, an invalid conversion does not write the result. Instead it raises an exception request and leaves the previous result in place.

Top module: `d2i_pack_trunc`

## Requirements
- R1: Operand bits [63:0] convert into result bits [31:0], and operand bits [127:64] convert into result bits [63:32]. The two lanes are independent.
- R2: A finite input whose truncated value lies in [-2^31, 2^31-1] produces that value in two's complement, with the fraction dropped toward zero for both signs (2.7 gives 2, -2.7 gives 0xFFFFFFFE).
- R3: A lane whose truncated value is at least 2^31 or below -2^31 sets flag_invalid. When inv_mask is 1, that lane's result is 0x80000000 and the other lane is still converted normally.
- R4: A NaN (quiet or signalling) or an infinity of either sign is invalid. When masked, it yields 0x80000000 in its lane.
- R5: An input whose truncated value is exactly -2^31 (for example -2147483648.0 or -2147483648.75) is valid and yields 0x80000000 without flag_invalid.
- R6: flag_inexact is set when a valid lane drops nonzero fraction bits. Subnormals and nonzero values of magnitude below 1.0 give 0 with flag_inexact. +0.0 and -0.0 give 0 with no flags.
- R7: Each flag is the OR of the two lanes' conditions. A lane that is invalid never contributes to flag_inexact.
- R8: When inv_mask is 0 and any lane is invalid, exc_req goes to 1, flag_invalid goes to 1 and the result keeps its previous value. The next strobe without an unmasked invalid lane clears exc_req.
- R9: Result, flags and exc_req update at the rising edge where in_strobe is 1 and hold while it is 0. A synchronous reset (rst = 1) clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_strobe | input | 1 | Starts a conversion of operand at this edge |
| inv_mask | input | 1 | 1: invalid lanes write 0x80000000; 0: invalid raises exc_req and the result is held |
| operand | input | 128 | Two packed doubles, lane 0 in [63:0] |
| result | output | 64 | Two packed signed 32-bit integers, lane 0 in [31:0] |
| flag_invalid | output | 1 | Some lane of the last conversion was invalid |
| flag_inexact | output | 1 | Some valid lane of the last conversion lost fraction bits |
| exc_req | output | 1 | Last conversion had an unmasked invalid lane |

## Verification
Inside each lane, the class decoder and the aligning shifter run in parallel. If the decoder assigns the wrong class, the lane shows a wrong value or a wrong flag on the first edge after the strobe. The boundary exponents (magnitude just below 1.0, the 2^31 edge, and the all-ones exponent) expose such errors, so the bench concentrates on them. A fault in the result hold path is different. After an unmasked trap, it leaves a stale or overwritten result that persists until the next accepted strobe. The bench therefore checks the result on the trap itself and again after idle cycles.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_MAN_W = 52;
  localparam int OUT_INT_W = 32;

  typedef enum logic [2:0] {
    CLS_ZERO    = 3'd0,
    CLS_TINY    = 3'd1,
    CLS_NORMAL  = 3'd2,
    CLS_EDGE    = 3'd3,
    CLS_OVF     = 3'd4,
    CLS_SPECIAL = 3'd5
  } lane_cls_e;
endpackage

// File: rtl/d2i_classify.sv
module d2i_classify
  import d2i_pkg::*;
#(
  parameter int EXP_W = DBL_EXP_W,
  parameter int MAN_W = DBL_MAN_W,
  parameter int INT_W = OUT_INT_W
) (
  input  logic             sign,
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] man,
  output lane_cls_e        cls
);
  localparam logic [EXP_W-1:0] BIAS_V   = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [EXP_W-1:0] EDGE_V   = BIAS_V + EXP_W'(INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam int               HI_W     = INT_W - 1;

  logic int_bits_clear;
  assign int_bits_clear = (man[MAN_W-1 -: HI_W] == '0);

  always_comb begin
    if (expo == EXP_ONES)                                cls = CLS_SPECIAL;
    else if (expo == '0)                                 cls = (man == '0) ? CLS_ZERO : CLS_TINY;
    else if (expo < BIAS_V)                              cls = CLS_TINY;
    else if (expo < EDGE_V)                              cls = CLS_NORMAL;
    else if (expo == EDGE_V && sign && int_bits_clear)   cls = CLS_EDGE;
    else                                                 cls = CLS_OVF;
  end
endmodule

// File: rtl/d2i_align.sv
module d2i_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] man,
  output logic [INT_W-1:0] mag,
  output logic             frac_nz
);
  localparam int               SIG_W  = MAN_W + 1;
  localparam int               SH_W   = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [EXP_W-1:0] TOP_V  = BIAS_V + EXP_W'(INT_W - 1);

  function automatic logic [EXP_W-1:0] clamp_unbiased(input logic [EXP_W-1:0] e);
    if (e < BIAS_V)     return '0;
    else if (e > TOP_V) return EXP_W'(INT_W - 1);
    else                return e - BIAS_V;
  endfunction

  function automatic logic [SIG_W-1:0] low_mask(input logic [SH_W-1:0] n);
    return (SIG_W'(1) << n) - SIG_W'(1);
  endfunction

  logic [SIG_W-1:0] sig, shifted;
  logic [EXP_W-1:0] unb;
  logic [SH_W-1:0]  rsh;

  always_comb begin
    sig     = {1'b1, man};
    unb     = clamp_unbiased(expo);
    rsh     = SH_W'(MAN_W) - SH_W'(unb);
    shifted = sig >> rsh;
    mag     = shifted[INT_W-1:0];
    frac_nz = |(sig & low_mask(rsh));
  end
endmodule

// File: rtl/d2i_lane.sv
module d2i_lane
  import d2i_pkg::*;
#(
  parameter int EXP_W = DBL_EXP_W,
  parameter int MAN_W = DBL_MAN_W,
  parameter int INT_W = OUT_INT_W
) (
  input  logic [EXP_W+MAN_W:0] fp_in,
  output logic [INT_W-1:0]     value,
  output logic                 invalid,
  output logic                 inexact
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  function automatic logic [INT_W-1:0] apply_sign(input logic s, input logic [INT_W-1:0] m);
    return s ? (~m + INT_W'(1)) : m;
  endfunction

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  lane_cls_e        cls;
  logic [INT_W-1:0] mag;
  logic             frac_nz;

  assign sgn  = fp_in[EXP_W+MAN_W];
  assign expo = fp_in[EXP_W+MAN_W-1 -: EXP_W];
  assign man  = fp_in[MAN_W-1:0];

  d2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cls (
    .sign(sgn), .expo(expo), .man(man), .cls(cls)
  );

  d2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_aln (
    .expo(expo), .man(man), .mag(mag), .frac_nz(frac_nz)
  );

  always_comb begin
    value   = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    unique case (cls)
      CLS_ZERO: ;
      CLS_TINY: inexact = 1'b1;
      CLS_NORMAL, CLS_EDGE: begin
        value   = apply_sign(sgn, mag);
        inexact = frac_nz;
      end
      default: begin
        value   = INDEF;
        invalid = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (cls == CLS_NORMAL) begin
      AST_NORMAL_FITS: assert (mag[INT_W-1] == 1'b0); // R3
    end
    if (cls == CLS_EDGE) begin
      AST_EDGE_MAG: assert (mag == INDEF); // R5
    end
  end
endmodule

// File: rtl/d2i_pack_trunc.sv
module d2i_pack_trunc
  import d2i_pkg::*;
#(
  parameter int LANES = 2,
  parameter int EXP_W = DBL_EXP_W,
  parameter int MAN_W = DBL_MAN_W,
  parameter int INT_W = OUT_INT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_strobe,
  input  logic                     inv_mask,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0] operand,
  output logic [LANES*INT_W-1:0]   result,
  output logic                     flag_invalid,
  output logic                     flag_inexact,
  output logic                     exc_req
);
  localparam int               FP_W  = EXP_W + MAN_W + 1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [LANES*INT_W-1:0] lane_val;
  logic [LANES-1:0]       lane_inv;
  logic [LANES-1:0]       lane_inx;
  logic                   any_inv, any_inx, raise_exc, take_result;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    d2i_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_lane (
      .fp_in  (operand[g*FP_W +: FP_W]),
      .value  (lane_val[g*INT_W +: INT_W]),
      .invalid(lane_inv[g]),
      .inexact(lane_inx[g])
    );

    AST_INDEF_MASKED: assert property (@(posedge clk) disable iff (rst)
      in_strobe && inv_mask && lane_inv[g] |=> result[g*INT_W +: INT_W] == INDEF); // R3
  end

  assign any_inv     = |lane_inv;
  assign any_inx     = |lane_inx;
  assign raise_exc   = any_inv && !inv_mask;
  assign take_result = in_strobe && !raise_exc;

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      exc_req      <= 1'b0;
    end else if (in_strobe) begin
      flag_invalid <= any_inv;
      flag_inexact <= any_inx;
      exc_req      <= raise_exc;
      if (take_result) result <= lane_val;
    end
  end

  AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    in_strobe && !inv_mask && any_inv |=> $stable(result) && exc_req); // R8

  AST_EXC_HAS_INV: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> flag_invalid); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_strobe |=> $stable(result) && $stable(flag_invalid) && $stable(flag_inexact) && $stable(exc_req)); // R9

  AST_INV_NO_INX: assert property (@(posedge clk) disable iff (rst)
    in_strobe && (&lane_inv) |=> !flag_inexact); // R7
endmodule

// File: tb/sim_d2i_pack_trunc.sv
`timescale 1ns/1ps
module sim_d2i_pack_trunc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_strobe = 1'b0;
  logic         inv_mask = 1'b1;
  logic [127:0] operand = '0;
  logic [63:0]  result;
  logic         flag_invalid, flag_inexact, exc_req;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [63:0] exp_prev = '0;

  always #2 clk = ~clk;

  d2i_pack_trunc u0 (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .inv_mask(inv_mask),
    .operand(operand), .result(result), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .exc_req(exc_req)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic model_lane(input logic [63:0] b, output logic [31:0] v,
                            output logic inv, output logic inx);
    real x;
    x   = $bitstoreal(b);
    v   = 32'h8000_0000;
    inv = 1'b0;
    inx = 1'b0;
    if (b[62:52] == 11'h7ff) inv = 1'b1;
    else if (x >= 2147483648.0 || x <= -2147483649.0) inv = 1'b1;
    else begin
      v   = $rtoi(x);
      inx = ($itor($signed(v)) != x);
    end
  endtask

  task automatic check_all(input string tag, input logic [63:0] er,
                           input logic ei, input logic ex, input logic ee);
    chk({tag, " result"}, result, er);
    chk({tag, " invalid"}, {63'd0, flag_invalid}, {63'd0, ei});
    chk({tag, " inexact"}, {63'd0, flag_inexact}, {63'd0, ex});
    chk({tag, " exc_req"}, {63'd0, exc_req}, {63'd0, ee});
  endtask

  task automatic apply(input string tag, input logic [63:0] lo, input logic [63:0] hi, input logic m);
    logic [31:0] v0, v1;
    logic i0, i1, x0, x1, trap;
    logic [63:0] er;
    model_lane(lo, v0, i0, x0);
    model_lane(hi, v1, i1, x1);
    trap = (i0 | i1) && !m;
    er   = trap ? exp_prev : {v1, v0};
    @(negedge clk);
    operand   = {hi, lo};
    inv_mask  = m;
    in_strobe = 1'b1;
    @(negedge clk);
    in_strobe = 1'b0;
    check_all(tag, er, i0 | i1, (x0 & !i0) | (x1 & !i1), trap);
    exp_prev = er;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9 reset", 64'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    exp_prev = '0;
  endtask

  task automatic t_lanes();
    apply("R1 lane order", $realtobits(5.0), $realtobits(-123.0), 1'b1);
    chk("R1 lane0 value", {32'd0, result[31:0]}, 64'd5);
    chk("R1 lane1 value", {32'd0, result[63:32]}, {32'd0, 32'hFFFF_FF85});
  endtask

  task automatic t_trunc();
    apply("R2 trunc +-2.7", $realtobits(2.7), $realtobits(-2.7), 1'b1);
    chk("R2 neg lane", {32'd0, result[63:32]}, {32'd0, 32'hFFFF_FFFE});
    apply("R2 near max", $realtobits(2147483647.999), $realtobits(-1.0), 1'b1);
    apply("R2 exact ints", $realtobits(1.0), $realtobits(-65536.0), 1'b1);
  endtask

  task automatic t_overflow();
    apply("R3 pos overflow masked", $realtobits(3.0e9), $realtobits(7.25), 1'b1);
    chk("R3 indef lane0", {32'd0, result[31:0]}, {32'd0, 32'h8000_0000});
    apply("R3 2^31 masked", $realtobits(-2147483649.0), $realtobits(2147483648.0), 1'b1);
  endtask

  task automatic t_special();
    apply("R4 qnan and -inf", 64'h7ff8_0000_0000_0000, 64'hfff0_0000_0000_0000, 1'b1);
    apply("R4 +inf and snan", 64'h7ff0_0000_0000_0000, 64'h7ff0_0000_0000_0001, 1'b1);
  endtask

  task automatic t_minint();
    apply("R5 exact -2^31", $realtobits(-2147483648.0), $realtobits(0.0), 1'b1);
    chk("R5 no invalid", {63'd0, flag_invalid}, 64'd0);
    apply("R5 -2^31 frac", $realtobits(-2147483648.75), $realtobits(3.0), 1'b1);
  endtask

  task automatic t_small();
    apply("R6 subnormal and -0.5", 64'h0000_0000_0000_0001, $realtobits(-0.5), 1'b1);
    apply("R6 signed zeros", 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1);
    apply("R6 just under one", $realtobits(0.9999999), $realtobits(4.0), 1'b1);
  endtask

  task automatic t_or();
    apply("R7 invalid lane hides inexact", $realtobits(1.0e10 + 0.5), $realtobits(8.0), 1'b1);
    apply("R7 inexact from lane1 only", $realtobits(8.0), $realtobits(9.5), 1'b1);
    apply("R7 both invalid", 64'h7ff8_0000_0000_0000, $realtobits(-5.0e12), 1'b1);
  endtask

  task automatic t_unmasked();
    apply("R8 setup", $realtobits(11.0), $realtobits(-22.0), 1'b1);
    apply("R8 unmasked trap holds", $realtobits(4.0e9), $realtobits(1.5), 1'b0);
    apply("R8 clear on next", $realtobits(3.5), $realtobits(6.0), 1'b0);
  endtask

  task automatic t_idle();
    logic [63:0] r;
    logic fi, fx, fe;
    apply("R9 load", $realtobits(-9.9), $realtobits(1.0e20), 1'b1);
    r = result; fi = flag_invalid; fx = flag_inexact; fe = exc_req;
    operand  = {$realtobits(77.0), $realtobits(88.0)};
    inv_mask = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 idle hold", r, fi, fx, fe);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R9 sync reset", 64'd0, 1'b0, 1'b0, 1'b0);
    exp_prev = '0;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lanes();
    t_trunc();
    t_overflow();
    t_special();
    t_minint();
    t_small();
    t_or();
    t_unmasked();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule